// File: doc/BRIEF.md
# Bus Show Cycle Generator

This block makes accesses on an internal bus visible on an external bus, so that an emulator, logic analyser or debug probe can follow them. Each internal access event (address, direction, data, an instruction-fetch flag and burst information) becomes one external show cycle. A show cycle has a one-clock address phase. For anything other than an instruction fetch, a one-clock data phase follows it. The block drives the data itself for reads as well as for writes. It never waits for a slave: the block has no acknowledge input, so every show cycle runs to completion at a fixed pace.

A burst on the internal bus produces a single show cycle, for its first beat only. The block tracks whether more beats are still to come and discards them as they arrive. An event that arrives while a show cycle is running goes into a one-entry holding slot and is shown directly after the current cycle ends. While that slot is occupied the block raises a busy flag, and it ignores any event offered in that state. Upstream logic uses the busy flag to hold back further events.

Top module: `show_cycle_gen`

## Requirements
- R1: While reset is asserted, and until the first event after reset, show_strobe, show_dphase, show_rw and evt_busy are 0, and show_addr and show_data are all zeros.
- R2: An event accepted at a clock edge while the block is idle (evt_valid=1, evt_busy=0) makes show_strobe 1 for exactly one clock right after that edge, with show_addr equal to the event address.
- R3: For an event with evt_ifetch=0, show_dphase is 1 for the clock after the address phase, and show_data carries the event data. This holds for read events (evt_write=0) as well as write events (evt_write=1).
- R4: The data phase lasts exactly one clock and is not extended for any reason. The clock after it has show_dphase=0, and show_strobe=0 unless another event is pending.
- R5: An event with evt_ifetch=1 produces an address phase only, with no data phase. Another event offered during that address phase gets its own address phase in the very next clock.
- R6: An event with evt_burst=1 and evt_more=1 starts a burst and is shown. Every later accepted event, up to and including the next one with evt_more=0, is discarded and produces no show cycle. An event with evt_burst=1 and evt_more=0 is shown as a single access.
- R7: An event accepted while a show cycle is in progress is held in the slot. Its address phase begins in the clock after the last phase of the current show cycle.
- R8: evt_busy is 1 in the clocks after an event has been placed in the slot, until that event's address phase begins. An event offered while evt_busy=1 is ignored and never shown.
- R9: Outside the address and data phases, show_addr, show_data and show_rw are driven to zero.
- R10: During the address phase, show_rw equals the event's evt_write flag (1 = write). During the data phase, show_rw is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | An internal access event is offered this clock |
| evt_addr | input | AW | Address of the internal access |
| evt_write | input | 1 | 1 for a write access, 0 for a read |
| evt_data | input | DW | Data read or written by the internal access |
| evt_ifetch | input | 1 | Access is an instruction fetch (address phase only) |
| evt_burst | input | 1 | Access is the first beat of a burst |
| evt_more | input | 1 | More beats of the current burst follow this one |
| evt_busy | output | 1 | Holding slot is full; offered events are ignored |
| show_strobe | output | 1 | Address phase of a show cycle |
| show_addr | output | AW | Show-cycle address, zero outside the address phase |
| show_rw | output | 1 | Direction during the address phase, zero otherwise |
| show_dphase | output | 1 | Data phase of a show cycle |
| show_data | output | DW | Show-cycle data, zero outside the data phase |

## Verification
An event accepted at a clock edge shows its address phase in the clock right after that edge. Its data phase follows one clock later, and the outputs return to idle one clock after that. An event that went into the slot appears one clock after the last phase of the cycle ahead of it, and evt_busy follows the slot contents with one register of delay. The bench drives inputs at the falling edge and samples at the next falling edge. It works out each expected phase from the number of rising edges since the event was offered, so each check falls in the single clock where its result is due. Cycles that must stay empty, such as dropped burst beats and events ignored while busy, are checked to be idle at the clock where a show cycle would otherwise have appeared.

// File: rtl/show_pkg.sv
package show_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/show_rst_sync.sv
module show_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/show_burst_filter.sv
module show_burst_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic evt_burst,
  input  logic evt_more,
  output logic drop
);

  logic in_burst_q;
  logic in_burst_d;
  logic in_burst_en;

  always_comb begin
    in_burst_en = take;
    if (in_burst_q) begin
      in_burst_d = evt_more;
    end else begin
      in_burst_d = evt_burst & evt_more;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst_q <= 1'b0;
    end else if (in_burst_en) begin
      in_burst_q <= in_burst_d;
    end
  end

  assign drop = take & in_burst_q;

endmodule

// File: rtl/show_evt_slot.sv
module show_evt_slot #(
  parameter int W = 66
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_evt,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] slot_evt
);

  logic         vld_q;
  logic         vld_d;
  logic [W-1:0] evt_q;

  always_comb begin
    vld_d = vld_q;
    if (pop) begin
      vld_d = 1'b0;
    end
    if (push) begin
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else if (push) begin
      evt_q <= push_evt;
    end
  end

  assign full     = vld_q;
  assign slot_evt = evt_q;

endmodule

// File: rtl/show_phase_fsm.sv
module show_phase_fsm
  import show_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int W = AW + DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          new_vld,
  input  logic [W-1:0]  new_evt,
  input  logic          slot_full,
  input  logic [W-1:0]  slot_evt,
  output logic          slot_push,
  output logic          slot_pop,
  output logic          show_strobe,
  output logic [AW-1:0] show_addr,
  output logic          show_rw,
  output logic          show_dphase,
  output logic [DW-1:0] show_data
);

  localparam int IF_BIT = W - 1;
  localparam int WR_BIT = W - 2;

  phase_e       ph_q, ph_d;
  logic [W-1:0] cur_q, cur_d;
  logic         cur_en;
  logic         ending;
  logic         cur_ifetch;

  assign cur_ifetch = cur_q[IF_BIT];

  always_comb begin
    ph_d      = ph_q;
    cur_d     = cur_q;
    cur_en    = 1'b0;
    slot_push = 1'b0;
    slot_pop  = 1'b0;
    ending    = (ph_q == PH_IDLE) || (ph_q == PH_DATA) ||
                ((ph_q == PH_ADDR) && cur_ifetch);
    if (ending) begin
      if (slot_full) begin
        ph_d     = PH_ADDR;
        cur_d    = slot_evt;
        cur_en   = 1'b1;
        slot_pop = 1'b1;
      end else if (new_vld) begin
        ph_d   = PH_ADDR;
        cur_d  = new_evt;
        cur_en = 1'b1;
      end else begin
        ph_d = PH_IDLE;
      end
    end else begin
      ph_d      = PH_DATA;
      slot_push = new_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= cur_d;
    end
  end

  always_comb begin
    show_strobe = (ph_q == PH_ADDR);
    show_dphase = (ph_q == PH_DATA);
    show_addr   = show_strobe ? cur_q[AW+DW-1:DW] : '0;
    show_rw     = show_strobe & cur_q[WR_BIT];
    show_data   = show_dphase ? cur_q[DW-1:0] : '0;
  end

endmodule

// File: rtl/show_cycle_gen.sv
module show_cycle_gen #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [AW-1:0] evt_addr,
  input  logic          evt_write,
  input  logic [DW-1:0] evt_data,
  input  logic          evt_ifetch,
  input  logic          evt_burst,
  input  logic          evt_more,
  output logic          evt_busy,
  output logic          show_strobe,
  output logic [AW-1:0] show_addr,
  output logic          show_rw,
  output logic          show_dphase,
  output logic [DW-1:0] show_data
);

  localparam int W = AW + DW + 2;

  logic         rst_q_n;
  logic         take;
  logic         drop;
  logic         new_vld;
  logic [W-1:0] new_evt;
  logic         slot_full;
  logic [W-1:0] slot_evt;
  logic         slot_push;
  logic         slot_pop;

  show_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign take    = evt_valid & ~slot_full;
  assign new_vld = take & ~drop;
  assign new_evt = {evt_ifetch, evt_write, evt_addr, evt_data};

  show_burst_filter burst_i (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .take      (take),
    .evt_burst (evt_burst),
    .evt_more  (evt_more),
    .drop      (drop)
  );

  show_evt_slot #(.W(W)) slot_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .push     (slot_push),
    .push_evt (new_evt),
    .pop      (slot_pop),
    .full     (slot_full),
    .slot_evt (slot_evt)
  );

  show_phase_fsm #(.AW(AW), .DW(DW)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .new_vld     (new_vld),
    .new_evt     (new_evt),
    .slot_full   (slot_full),
    .slot_evt    (slot_evt),
    .slot_push   (slot_push),
    .slot_pop    (slot_pop),
    .show_strobe (show_strobe),
    .show_addr   (show_addr),
    .show_rw     (show_rw),
    .show_dphase (show_dphase),
    .show_data   (show_data)
  );

  assign evt_busy = slot_full;

endmodule

// File: rtl/show_cycle_chk.sv
module show_cycle_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_busy,
  input logic          show_strobe,
  input logic [AW-1:0] show_addr,
  input logic          show_rw,
  input logic          show_dphase,
  input logic [DW-1:0] show_data
);

  // R3
  dphase_follows_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    show_dphase |-> $past(show_strobe));

  // R4
  dphase_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    show_dphase |=> !show_dphase);

  // R2
  phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(show_strobe && show_dphase));

  // R8
  busy_only_in_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_busy) |-> $past(show_strobe || show_dphase));

  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!show_strobe && !show_dphase) |-> (show_addr == '0 && show_data == '0 && !show_rw));

  // R10
  rw_quiet_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    show_dphase |-> !show_rw);

endmodule

bind show_cycle_gen show_cycle_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_busy    (evt_busy),
  .show_strobe (show_strobe),
  .show_addr   (show_addr),
  .show_rw     (show_rw),
  .show_dphase (show_dphase),
  .show_data   (show_data)
);

// File: tb/show_cycle_gen_tb.sv
`timescale 1ns/1ps
module show_cycle_gen_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NV = 6;
  localparam int VW = AW + DW + 2;

  // vector: {ifetch, write, addr, data}
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {1'b0, 1'b1, 32'h0000_1000, 32'hDEAD_BEEF},
    {1'b0, 1'b0, 32'h0000_2004, 32'h1234_5678},
    {1'b1, 1'b0, 32'h0000_3008, 32'h0000_0000},
    {1'b0, 1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 32'h8000_0000, 32'h0000_0001},
    {1'b1, 1'b0, 32'h0040_0010, 32'hAAAA_5555}
  };

  logic          clk;
  logic          rst_n;
  logic          evt_valid;
  logic [AW-1:0] evt_addr;
  logic          evt_write;
  logic [DW-1:0] evt_data;
  logic          evt_ifetch;
  logic          evt_burst;
  logic          evt_more;
  logic          evt_busy;
  logic          show_strobe;
  logic [AW-1:0] show_addr;
  logic          show_rw;
  logic          show_dphase;
  logic [DW-1:0] show_data;

  int n_tests;
  int n_fail;
  bit done;

  show_cycle_gen #(.AW(AW), .DW(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_addr    (evt_addr),
    .evt_write   (evt_write),
    .evt_data    (evt_data),
    .evt_ifetch  (evt_ifetch),
    .evt_burst   (evt_burst),
    .evt_more    (evt_more),
    .evt_busy    (evt_busy),
    .show_strobe (show_strobe),
    .show_addr   (show_addr),
    .show_rw     (show_rw),
    .show_dphase (show_dphase),
    .show_data   (show_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic offer(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] d,
                       input logic ifx, input logic bu, input logic mo);
    evt_valid  = 1'b1;
    evt_addr   = a;
    evt_write  = wr;
    evt_data   = d;
    evt_ifetch = ifx;
    evt_burst  = bu;
    evt_more   = mo;
  endtask

  task automatic quiet();
    evt_valid  = 1'b0;
    evt_addr   = '0;
    evt_write  = 1'b0;
    evt_data   = '0;
    evt_ifetch = 1'b0;
    evt_burst  = 1'b0;
    evt_more   = 1'b0;
  endtask

  task automatic chk_idle(input string req);
    chk(req, "strobe idle", 64'(show_strobe), 64'd0);
    chk(req, "dphase idle", 64'(show_dphase), 64'd0);
    chk(req, "addr idle",   64'(show_addr),   64'd0);
    chk(req, "data idle",   64'(show_data),   64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    quiet();
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    chk("R1", "busy in reset", 64'(evt_busy), 64'd0);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", 64'(evt_busy), 64'd0);
    chk_idle("R1");

    // table walk: isolated events
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      offer(v[AW+DW-1:DW], v[VW-2], v[DW-1:0], v[VW-1], 1'b0, 1'b0);
      @(negedge clk);
      quiet();
      chk("R2", "address phase strobe", 64'(show_strobe), 64'd1);
      chk("R2", "address value", 64'(show_addr), 64'(v[AW+DW-1:DW]));
      chk("R10", "rw in address phase", 64'(show_rw), 64'(v[VW-2]));
      @(negedge clk);
      chk("R2", "strobe one clock", 64'(show_strobe), 64'd0);
      if (v[VW-1]) begin
        chk("R5", "no data phase for fetch", 64'(show_dphase), 64'd0);
      end else begin
        chk("R3", "data phase", 64'(show_dphase), 64'd1);
        chk("R3", "data value", 64'(show_data), 64'(v[DW-1:0]));
        chk("R10", "rw in data phase", 64'(show_rw), 64'd0);
        @(negedge clk);
        chk("R4", "data phase one clock", 64'(show_dphase), 64'd0);
      end
      chk_idle("R9");
      @(negedge clk);
    end

    // R7 / R8: slot fill, busy, ignored event
    offer(32'h0000_A000, 1'b1, 32'h0000_00AA, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2", "A address", 64'(show_addr), 64'h0000_A000);
    offer(32'h0000_B000, 1'b0, 32'h0000_00BB, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3", "A data", 64'(show_data), 64'h0000_00AA);
    chk("R8", "busy after slot fill", 64'(evt_busy), 64'd1);
    offer(32'h0000_C000, 1'b1, 32'h0000_00CC, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    quiet();
    chk("R7", "B address right after A", 64'(show_strobe), 64'd1);
    chk("R7", "B address value", 64'(show_addr), 64'h0000_B000);
    chk("R8", "busy cleared", 64'(evt_busy), 64'd0);
    @(negedge clk);
    chk("R7", "B data", 64'(show_data), 64'h0000_00BB);
    @(negedge clk);
    chk("R8", "busy-time event ignored", 64'(show_strobe), 64'd0);
    chk_idle("R8");
    @(negedge clk);
    chk_idle("R8");

    // R5: back-to-back instruction fetches
    offer(32'h0000_0100, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    offer(32'h0000_0104, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    chk("R5", "fetch 1 address", 64'(show_addr), 64'h0000_0100);
    @(negedge clk);
    quiet();
    chk("R5", "fetch 2 next clock", 64'(show_strobe), 64'd1);
    chk("R5", "fetch 2 address", 64'(show_addr), 64'h0000_0104);
    chk("R5", "no busy on fetch chain", 64'(evt_busy), 64'd0);
    @(negedge clk);
    chk_idle("R5");

    // R6: burst of four beats, then a single event
    offer(32'h0000_5000, 1'b0, 32'h0000_0050, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R6", "first beat address", 64'(show_addr), 64'h0000_5000);
    offer(32'h0000_5004, 1'b0, 32'h0000_0054, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R6", "first beat data", 64'(show_data), 64'h0000_0050);
    offer(32'h0000_5008, 1'b0, 32'h0000_0058, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R6", "beat 2 dropped", 64'(show_strobe), 64'd0);
    offer(32'h0000_500C, 1'b0, 32'h0000_005C, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R6", "beat 3 dropped", 64'(show_strobe), 64'd0);
    offer(32'h0000_6000, 1'b1, 32'h0000_0060, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    quiet();
    chk("R6", "beat 4 dropped then next shown", 64'(show_strobe), 64'd1);
    chk("R6", "next event address", 64'(show_addr), 64'h0000_6000);
    @(negedge clk);
    @(negedge clk);

    // R6: burst flag without more beats is a single access
    offer(32'h0000_7000, 1'b0, 32'h0000_0070, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    offer(32'h0000_7100, 1'b0, 32'h0000_0071, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    quiet();
    chk("R6", "single burst beat data", 64'(show_data), 64'h0000_0070);
    @(negedge clk);
    chk("R6", "following event not dropped", 64'(show_addr), 64'h0000_7100);

    // R1: reset in mid show cycle
    @(negedge clk);
    offer(32'h0000_9000, 1'b1, 32'h0000_0090, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    quiet();
    #1;
    chk("R1", "strobe cleared by reset", 64'(show_strobe), 64'd0);
    do_reset();
    chk_idle("R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule